// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Fill Status

This block buffers 9-bit words between two unrelated clocks. Words enter on the write clock through a valid/ready pair. They leave on the read clock through a second valid/ready pair, in the order they were written. The default depth is 2048 words, and the depth is a parameter. Separate full and empty pins are replaced by a single three-bit status code that names one of six fill states. The empty-side states come from the read clock domain. The full-side states come from the write clock domain. Each domain learns of the other's pointer movement through a two-flop synchronizer of a Gray-coded pointer.

Two distances can be programmed in 16-word steps: the almost-empty distance and the almost-full distance. A program-mode input redirects write transfers into these threshold codes, and redirects read transfers to return the selected code on the data output. A hold input freezes a mark pointer in the read domain, and a rewind pulse moves the read pointer back to that mark, so a block of words can be read again. Storage is released to the writer only as the mark advances. Retained words therefore cannot be overwritten.

Back-pressure works as follows. A write transfer happens on a write-clock edge where `wr_valid` and `wr_ready` are both high. A read transfer happens on a read-clock edge where `rd_ready` and `rd_valid` are both high, and the word appears on `rd_data` after that edge. Outside program mode, `wr_ready` is low only when the FIFO is full, and `rd_valid` is low only when it is empty.

Top module: `dcf_fifo`

## Requirements
- R1: Words are returned on `rd_data` in the order they were accepted, with none lost or duplicated, for any fill up to the 2048-word default depth.
- R2: `status` only ever shows one of these codes: 000 empty, 001 near empty, 010 at or below half, 011 above half, 100 near full, 101 full.
- R3: On the write-clock edge that accepts the word raising the count to the depth, `status` becomes 101 and `wr_ready` drops.
- R4: While the FIFO is full, `wr_valid` pulses are ignored: the stored count and contents do not change.
- R5: A read request while empty is ignored: `rd_valid` is low and `rd_data` keeps its last value.
- R6: With no near-full condition, `status` is 010 for counts from the near-empty limit + 1 up to depth/2 (1024), and 011 from depth/2 + 1 (1025).
- R7: `status` is 001 for counts 1 to 16 × near-empty code, and 100 for counts from depth − 16 × near-full code up to depth − 1.
- R8: With `prog` high, an accepted write loads `wr_data[TW-1:0]` (TW = 6 at the default depth) into the near-empty code when `thr_sel` is 0, or into the near-full code when `thr_sel` is 1, and stores no word in the FIFO.
- R9: With `prog` high, a read request places the selected code (`thr_sel` 0 near-empty, 1 near-full), zero-extended, on `rd_data` after that read edge, and pops nothing.
- R10: After reset, `status` is 000, `rd_valid` is 0, `wr_ready` is 1, and both threshold codes are 1 (16 words).
- R11: A write reaches the read-domain status only after the two-stage synchronizer. Within the first half write-clock period after the first write, `status` still shows 000.
- R12: While `keep` is high, the mark stays fixed and reads free no space. A one-cycle `rt_go` pulse moves the read pointer back to the mark, and the same words are then read again.
- R13: While `keep` is low, the mark advances one step per read-clock cycle towards the read pointer, and the space it passes is returned to the writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prog | input | 1 | Program mode: transfers access the threshold codes |
| thr_sel | input | 1 | Threshold select: 0 near-empty, 1 near-full |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write accepted this edge if valid |
| wr_data | input | 9 | Write word, or threshold code in program mode |
| rd_ready | input | 1 | Read request |
| rd_valid | output | 1 | A read request will be served |
| rd_data | output | 9 | Registered read word or threshold readback |
| rt_go | input | 1 | Rewind read pointer to the mark |
| keep | input | 1 | Freeze the mark to retain words for rewind |
| status | output | 3 | Encoded fill state |

## Verification
The bench walks the fill level across every state edge: 16/17 words for near-empty, 1024/1025 around half, 2031/2032 into near-full, and 2047/2048 into full. An off-by-one comparator would show up as a wrong code at exactly one of these counts. Writes are hammered while the FIFO is full and the contents are then drained, so a design that overwrote the oldest word or advanced its pointer would show up as a wrong word in the sequence. A rewind test with `keep` high checks that a read frees no space and that the same words come back. A design that synchronized the live read pointer instead of the mark would reopen `wr_ready` and lose those words. Threshold programming is checked both by readback and by the moved near-empty boundary, and status is sampled just after the first write to catch a design that bypasses the synchronizer.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [2:0] {
    FILL_EMPTY = 3'd0,
    FILL_NEAR_EMPTY = 3'd1,
    FILL_LOWER = 3'd2,
    FILL_UPPER = 3'd3,
    FILL_NEAR_FULL = 3'd4,
    FILL_FULL = 3'd5
  } fill_code_e;

  // Threshold codes count in steps of 1 << STEP_SHIFT words
  localparam int unsigned STEP_SHIFT = 4;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 12,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
  import dcf_pkg::*;
#(
  parameter int DW = 9,
  parameter int DEPTH = 2048,
  parameter int AW = 11,
  parameter int PW = 12,
  parameter int TW = 6
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          thr_sel,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wptr_gray,
  input  logic [PW-1:0] mark_gray_s,
  output logic [TW-1:0] ae_code,
  output logic [TW-1:0] af_code,
  output logic          near_full,
  output logic          full
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wptr_bin, wptr_next, mark_bin, wcount, af_dist;

  // Gray to binary for the synchronized mark
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc = acc ^ mark_gray_s[i];
      mark_bin[i] = acc;
    end
  end

  assign wcount    = wptr_bin - mark_bin;
  assign af_dist   = PW'(af_code) << STEP_SHIFT;
  assign full      = (wcount == DEPTH_P);
  assign near_full = !full && (wcount >= DEPTH_P - af_dist);
  assign wr_ready  = prog | ~full;
  assign we        = wr_valid & ~prog & ~full;
  assign waddr     = wptr_bin[AW-1:0];
  assign wptr_next = wptr_bin + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (we) begin
      wptr_bin  <= wptr_next;
      wptr_gray <= wptr_next ^ (wptr_next >> 1);
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_code <= TW'(1);
      af_code <= TW'(1);
    end else if (prog && wr_valid) begin
      if (thr_sel) af_code <= wr_data[TW-1:0];
      else         ae_code <= wr_data[TW-1:0];
    end
  end

  // R3: stored count never exceeds the depth
  p_count_bound_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= DEPTH_P);
  // R4: a full FIFO keeps its write pointer
  p_full_ignore_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_valid && !prog) |=> $stable(wptr_bin));
  // R8: program-mode writes never push a word
  p_prog_no_push_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    (prog && wr_valid) |=> $stable(wptr_bin));
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
  import dcf_pkg::*;
#(
  parameter int DW = 9,
  parameter int DEPTH = 2048,
  parameter int AW = 11,
  parameter int PW = 12,
  parameter int TW = 6
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          thr_sel,
  input  logic          rd_ready,
  input  logic          rt_go,
  input  logic          keep,
  input  logic [PW-1:0] wptr_gray_s,
  input  logic [TW-1:0] ae_code_s,
  input  logic [TW-1:0] af_code_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] mark_gray,
  output logic [2:0]    rcode
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] rptr_bin, mark_bin, mark_next, wbin, rcount, ae_dist;
  logic empty, pop, mark_step;
  fill_code_e code;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc = acc ^ wptr_gray_s[i];
      wbin[i] = acc;
    end
  end

  assign rcount    = wbin - rptr_bin;
  assign empty     = (rcount == '0);
  assign ae_dist   = PW'(ae_code_s) << STEP_SHIFT;
  assign rd_valid  = prog | ~empty;
  assign pop       = rd_ready & ~prog & ~empty & ~rt_go;
  assign raddr     = rptr_bin[AW-1:0];
  assign mark_step = !keep && (mark_bin != rptr_bin);
  assign mark_next = mark_bin + PW'(1);

  always_comb begin
    if (empty)                 code = FILL_EMPTY;
    else if (rcount <= ae_dist) code = FILL_NEAR_EMPTY;
    else if (rcount <= HALF_P)  code = FILL_LOWER;
    else                        code = FILL_UPPER;
  end
  assign rcode = code;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) rptr_bin <= '0;
    else if (rt_go) rptr_bin <= mark_bin;
    else if (pop) rptr_bin <= rptr_bin + PW'(1);
  end

  // Mark moves one step at a time so its Gray code changes one bit per cycle
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      mark_bin  <= '0;
      mark_gray <= '0;
    end else if (mark_step) begin
      mark_bin  <= mark_next;
      mark_gray <= mark_next ^ (mark_next >> 1);
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (prog && rd_ready) rd_data <= DW'(thr_sel ? af_code_s : ae_code_s);
    else if (pop) rd_data <= mem_rdata;
  end

  // R1: read side never sees more than the depth stored
  p_count_bound_r1: assert property (@(posedge rclk) disable iff (!rst_n)
    rcount <= DEPTH_P);
  // R5: empty read keeps the output word
  p_empty_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_ready && !prog && !rt_go) |=> $stable(rd_data));
  // R12: rewind lands on the mark
  p_rewind_r12: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_go |=> (rptr_bin == $past(mark_bin)));
  // R13: mark Gray code changes at most one bit per cycle
  p_mark_step_r13: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(mark_gray ^ $past(mark_gray)) <= 1);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DW = 9,
  parameter int DEPTH = 2048
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          thr_sel,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rt_go,
  input  logic          keep,
  output logic [2:0]    status
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int TW = $clog2(DEPTH / 32);
  localparam logic [2*TW-1:0] THR_RST = {TW'(1), TW'(1)};

  logic          we, near_full, full;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] wptr_gray, wptr_gray_s, mark_gray, mark_gray_s;
  logic [TW-1:0] ae_code, af_code, ae_code_s, af_code_s;
  logic [2:0]    rcode;

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_wside #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW), .TW(TW)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .prog(prog), .thr_sel(thr_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .we(we), .waddr(waddr), .wptr_gray(wptr_gray), .mark_gray_s(mark_gray_s),
    .ae_code(ae_code), .af_code(af_code), .near_full(near_full), .full(full)
  );

  dcf_sync #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst_n(rst_n), .d(wptr_gray), .q(wptr_gray_s)
  );

  dcf_sync #(.W(PW)) u_mark_sync (
    .clk(wclk), .rst_n(rst_n), .d(mark_gray), .q(mark_gray_s)
  );

  // Threshold codes are quasi-static: changed only in program mode while idle
  dcf_sync #(.W(2*TW), .RST(THR_RST)) u_thr_sync (
    .clk(rclk), .rst_n(rst_n), .d({ae_code, af_code}), .q({ae_code_s, af_code_s})
  );

  dcf_rside #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW), .TW(TW)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .prog(prog), .thr_sel(thr_sel),
    .rd_ready(rd_ready), .rt_go(rt_go), .keep(keep),
    .wptr_gray_s(wptr_gray_s), .ae_code_s(ae_code_s), .af_code_s(af_code_s),
    .mem_rdata(mem_rdata), .raddr(raddr), .rd_valid(rd_valid),
    .rd_data(rd_data), .mark_gray(mark_gray), .rcode(rcode)
  );

  always_comb begin
    if (full)           status = FILL_FULL;
    else if (near_full) status = FILL_NEAR_FULL;
    else                status = rcode;
  end

  // R2: only the six defined codes appear
  p_code_legal_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    status <= 3'd5);
  // R3: full and write-ready are never high together outside program mode
  p_full_ready_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (status == 3'd5 && !prog) |-> !wr_ready);
endmodule

// File: tb/sim_dcf_fifo.sv
module sim_dcf_fifo;
  localparam int WCLK_NS = 10;
  localparam int RCLK_NS = 14;
  localparam int DEPTH = 2048;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic prog = 0, thr_sel = 0, wr_valid = 0, rd_ready = 0, rt_go = 0, keep = 0;
  logic [8:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [8:0] rd_data;
  logic [2:0] status;

  int checks = 0, fails = 0;
  int widx = 0, ridx = 0, midx = 0;
  logic [8:0] exp_mem [0:8191];

  always #(WCLK_NS/2) wclk = ~wclk;
  always #(RCLK_NS/2) rclk = ~rclk;

  dcf_fifo u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prog(prog), .thr_sel(thr_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rt_go(rt_go), .keep(keep), .status(status)
  );

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    @(negedge rclk);
  endtask

  task automatic push_n(int n);
    @(negedge wclk);
    for (int i = 0; i < n; i++) begin
      exp_mem[widx] = 9'(widx * 37 + 5);
      wr_data = exp_mem[widx];
      wr_valid = 1;
      @(posedge wclk);
      widx++;
      @(negedge wclk);
    end
    wr_valid = 0;
  endtask

  // Reads n words, returns mismatch count
  task automatic pop_n(int n, output int errs);
    errs = 0;
    @(negedge rclk);
    for (int i = 0; i < n; i++) begin
      rd_ready = 1;
      @(posedge rclk);
      @(negedge rclk);
      if (rd_data !== exp_mem[ridx]) errs++;
      ridx++;
    end
    rd_ready = 0;
  endtask

  task automatic readback(int exp_ae, int exp_af, string req);
    @(negedge rclk);
    prog = 1; thr_sel = 0; rd_ready = 1;
    @(posedge rclk); @(negedge rclk);
    rd_ready = 0;
    check_eq({req, " near-empty code"}, rd_data, exp_ae);
    thr_sel = 1; rd_ready = 1;
    @(posedge rclk); @(negedge rclk);
    rd_ready = 0;
    check_eq({req, " near-full code"}, rd_data, exp_af);
    prog = 0; thr_sel = 0;
  endtask

  task automatic t_reset();
    settle();
    check_eq("R10 status", status, 0);
    check_eq("R10 rd_valid", rd_valid, 0);
    check_eq("R10 wr_ready", wr_ready, 1);
    readback(1, 1, "R10 R9");
  endtask

  task automatic t_first_word();
    push_n(1);
    check_eq("R11 status before sync", status, 0);
    check_eq("R11 rd_valid before sync", rd_valid, 0);
    settle();
    check_eq("R7 near-empty at 1", status, 1);
  endtask

  task automatic t_levels();
    push_n(15);  settle(); check_eq("R7 near-empty at 16", status, 1);
    push_n(1);   settle(); check_eq("R6 lower at 17", status, 2);
    push_n(1007); settle(); check_eq("R6 lower at 1024", status, 2);
    push_n(1);   settle(); check_eq("R6 upper at 1025", status, 3);
    push_n(1006); settle(); check_eq("R6 upper at 2031", status, 3);
    push_n(1);   settle(); check_eq("R7 near-full at 2032", status, 4);
    push_n(15);  settle(); check_eq("R7 near-full at 2047", status, 4);
    push_n(1);
    check_eq("R3 full on write edge", status, 5);
    check_eq("R3 wr_ready low", wr_ready, 0);
  endtask

  task automatic t_full_ignore();
    @(negedge wclk);
    wr_valid = 1; wr_data = 9'h1AA;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    check_eq("R4 wr_ready while full", wr_ready, 0);
    wr_valid = 0;
    settle();
    check_eq("R4 status still full", status, 5);
  endtask

  task automatic t_retain();
    int errs;
    @(negedge rclk); keep = 1;
    midx = ridx;
    pop_n(2, errs);
    check_eq("R1 first two words", errs, 0);
    settle();
    check_eq("R12 no space freed under keep", wr_ready, 0);
    @(negedge rclk); rt_go = 1;
    @(posedge rclk); @(negedge rclk); rt_go = 0;
    ridx = midx;
    pop_n(2, errs);
    check_eq("R12 rewound words repeat", errs, 0);
    @(negedge rclk); keep = 0;
    settle();
    check_eq("R13 space returned", wr_ready, 1);
    check_eq("R7 near-full at 2046", status, 4);
    push_n(1);
    pop_n(widx - ridx, errs);
    check_eq("R1 R4 drain order", errs, 0);
    check_eq("R5 rd_valid after last read", rd_valid, 0);
    settle();
    check_eq("R2 status empty after drain", status, 0);
  endtask

  task automatic t_empty_read();
    logic [8:0] last;
    last = rd_data;
    @(negedge rclk); rd_ready = 1;
    repeat (2) @(posedge rclk);
    @(negedge rclk); rd_ready = 0;
    check_eq("R5 rd_data held", rd_data, last);
    check_eq("R5 rd_valid low", rd_valid, 0);
  endtask

  task automatic t_program();
    int errs;
    @(negedge wclk);
    prog = 1; wr_valid = 1; thr_sel = 0; wr_data = 9'd3;
    @(posedge wclk); @(negedge wclk);
    thr_sel = 1; wr_data = 9'd2;
    @(posedge wclk); @(negedge wclk);
    wr_valid = 0; prog = 0; thr_sel = 0;
    settle();
    check_eq("R8 no word stored", status, 0);
    readback(3, 2, "R8 R9");
    push_n(48); settle(); check_eq("R7 programmed near-empty at 48", status, 1);
    push_n(1);  settle(); check_eq("R7 programmed lower at 49", status, 2);
    pop_n(49, errs);
    check_eq("R1 drain after program", errs, 0);
  endtask

  initial begin
    #(WCLK_NS * 150000);
    fails++;
    $display("FAIL watchdog R1 act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(WCLK_NS * 3 + 2);
    rst_n = 1;
    t_reset();
    t_first_word();
    t_levels();
    t_full_ignore();
    t_retain();
    t_empty_read();
    t_program();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule